// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Data and Line Inversion

This block is a full-duplex asynchronous serial port for bytes. The transmitter accepts a byte over a ready/valid handshake and sends it as a frame on `txd`. The frame is a start bit, eight data bits, an optional parity bit and one or two stop bits. The receiver watches `rxd`, rebuilds frames of the same shape and presents each byte with a valid level and three error flags. Bit timing comes from a free-running clock divider. The divider produces a tick at sixteen times the bit rate. The transmitter holds each bit for sixteen ticks. The receiver samples each bit at its middle.

Two inversion controls act independently of each other. The data inversion control complements only the payload: the byte is complemented before it is shifted out, and a received byte is complemented before it reaches `rx_data`. The line inversion control complements the pin level in both directions. That covers the idle level, the start, stop and parity bits, and the received input before any start detection. Parity is computed over the data bits as they appear on the line, so it is taken after data inversion. The frame settings are bit order, stop count, parity enable and parity sense. Each direction captures them when a frame begins.

Top module: `serline_uart`

## Requirements
- R1: A frame is one start bit at logical 0, the data bits, an optional parity bit, and stop bits at logical 1. Each bit lasts 16 divider ticks. `tx_ready` is high only while the transmitter is idle, and a byte is taken on a cycle with `tx_valid` and `tx_ready` both high.
- R2: With `cfg_msb_first` = 0 the data bits go out and come in starting with bit 0. With `cfg_msb_first` = 1 they start with bit 7.
- R3: With `cfg_two_stop` = 0 a frame carries one stop bit. With `cfg_two_stop` = 1 it carries two, and `tx_ready` stays low until the second stop bit ends.
- R4: With `cfg_par_en` = 1 a parity bit follows the last data bit. It is computed over the eight data bits as placed on the line. With `cfg_par_odd` = 0 the count of ones over data and parity is even; with `cfg_par_odd` = 1 it is odd.
- R5: With `cfg_data_inv` = 1 the transmitted data bits are the complement of `tx_data`, and `rx_data` is the complement of the received data bits. Start, stop and parity logic are unaffected.
- R6: With `cfg_line_inv` = 1, `txd` is the complement of the logical line level at all times, so the idle level is low. `rxd` is also complemented before start detection and sampling. The two inversion controls combine freely.
- R7: A start is detected on a falling logical edge. It is accepted only if the line is still at logical 0 at the half-bit sample, so a shorter pulse produces no byte.
- R8: When a stop bit is sampled at logical 0, the byte is delivered with `rx_frame_err` = 1.
- R9: When parity is enabled and the received parity bit does not match the rule of R4, the byte is delivered with `rx_par_err` = 1.
- R10: When a byte completes while `rx_valid` is still high, `rx_data` takes the new byte and `rx_overrun` = 1.
- R11: `rx_valid` and its flags hold until a cycle with `rx_ack` high, which clears all of them. The flags are never high while `rx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_data_inv | input | 1 | Complement the data payload in both directions |
| cfg_line_inv | input | 1 | Complement the pin levels of txd and rxd |
| cfg_msb_first | input | 1 | 1: data bit 7 first; 0: data bit 0 first |
| cfg_two_stop | input | 1 | 1: two stop bits; 0: one stop bit |
| cfg_par_en | input | 1 | Insert and check a parity bit |
| cfg_par_odd | input | 1 | 1: odd parity; 0: even parity |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | Byte on tx_data is offered |
| tx_ready | output | 1 | Transmitter idle, accepts a byte |
| txd | output | 1 | Serial output pin |
| rxd | input | 1 | Serial input pin |
| rx_ack | input | 1 | Consumer takes the held byte |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | rx_data holds an unread byte |
| rx_frame_err | output | 1 | Held byte had a stop bit at logical 0 |
| rx_par_err | output | 1 | Held byte failed its parity check |
| rx_overrun | output | 1 | Held byte replaced an unread one |

## Verification
The error cases are the hardest to reach from the ports. The transmitter never produces a bad stop bit, a wrong parity bit or a runt start pulse, and back-to-back frames reach the receiver only if nobody acknowledges. The bench therefore drives `rxd` itself from a frame it builds from the requirements, then corrupts a single bit: it clears the stop bit, flips the parity bit or cuts the start pulse to a quarter bit. It also sends two frames with `rx_ack` held low. A loopback mode ties `txd` to `rxd` and checks all four combinations of the two inversion controls end to end.

// File: rtl/serline_pkg.sv
// Package: shared types for the serial transceiver.
// Assumes: both directions use the same frame shape and phase encoding.
package serline_pkg;

    // Frame settings captured at the start of each frame.
    typedef struct packed {
        logic data_inv;
        logic msb_first;
        logic two_stop;
        logic par_en;
        logic par_odd;
    } frame_cfg_t;

    // Position inside a frame.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_e;

endpackage

// File: rtl/serline_tick.sv
// Module: serline_tick
// Produces a one-cycle tick every DIV clocks. The tick rate is the
// oversampling rate, so it runs at OVS times the bit rate.
// Assumes: DIV >= 1; the tick runs freely from reset.
module serline_tick #(
    parameter int DIV = 27
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count clocks modulo DIV.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/serline_tx.sv
// Module: serline_tx
// Frame transmitter. It takes a byte on a valid/ready handshake and drives the
// logical line level (1 = mark) for start, data, optional parity and stop bits.
// Each bit lasts OVS ticks.
// Assumes: the caller applies line polarity; the settings are sampled at accept.
module serline_tx
    import serline_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  frame_cfg_t        cfg,
    input  logic [DATA_W-1:0] data,
    input  logic              valid,
    output logic              ready,
    output logic              line
);
    localparam int SUB_W = $clog2(OVS);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [SUB_W-1:0] SUB_END  = SUB_W'(OVS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    phase_e            phase;
    logic [SUB_W-1:0]  sub;
    logic [IDX_W-1:0]  idx;
    logic              stop_left;
    logic [DATA_W-1:0] payload;
    logic              msb_q, two_q, pen_q, odd_q;
    logic              par_bit;
    logic [IDX_W-1:0]  nxt_idx;

    // Select the data bit in slot i for the captured bit order.
    function automatic logic pick(input logic [DATA_W-1:0] v,
                                  input logic [IDX_W-1:0]  i,
                                  input logic              msb);
        pick = msb ? v[IDX_LAST - i] : v[i];
    endfunction

    // Compute the parity bit from the payload as it appears on the line.
    always_comb begin
        par_bit = (^payload) ^ odd_q;
        nxt_idx = idx + 1'b1;
    end

    // Step through the frame phases, one bit per OVS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            sub       <= '0;
            idx       <= '0;
            stop_left <= 1'b0;
            payload   <= '0;
            msb_q     <= 1'b0;
            two_q     <= 1'b0;
            pen_q     <= 1'b0;
            odd_q     <= 1'b0;
            line      <= 1'b1;
        end else if (phase == PH_IDLE) begin
            line <= 1'b1;
            if (valid) begin
                payload <= cfg.data_inv ? ~data : data;
                msb_q   <= cfg.msb_first;
                two_q   <= cfg.two_stop;
                pen_q   <= cfg.par_en;
                odd_q   <= cfg.par_odd;
                sub     <= '0;
                phase   <= PH_START;
                line    <= 1'b0;
            end
        end else if (tick) begin
            if (sub != SUB_END) begin
                sub <= sub + 1'b1;
            end else begin
                sub <= '0;
                unique case (phase)
                    PH_START: begin
                        phase <= PH_DATA;
                        idx   <= '0;
                        line  <= pick(payload, '0, msb_q);
                    end
                    PH_DATA: begin
                        if (idx == IDX_LAST) begin
                            stop_left <= two_q;
                            if (pen_q) begin
                                phase <= PH_PAR;
                                line  <= par_bit;
                            end else begin
                                phase <= PH_STOP;
                                line  <= 1'b1;
                            end
                        end else begin
                            idx  <= nxt_idx;
                            line <= pick(payload, nxt_idx, msb_q);
                        end
                    end
                    PH_PAR: begin
                        phase <= PH_STOP;
                        line  <= 1'b1;
                    end
                    PH_STOP: begin
                        if (stop_left) begin
                            stop_left <= 1'b0;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    assign ready = (phase == PH_IDLE);
endmodule

// File: rtl/serline_rx.sv
// Module: serline_rx
// Frame receiver. It synchronises the pin and applies line polarity, detects a
// falling logical edge, confirms the start at half a bit, then samples every
// bit at its middle. It emits a one-cycle done pulse with the byte and its flags.
// Assumes: the pin is asynchronous; the settings are sampled at start detect.
module serline_rx
    import serline_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  frame_cfg_t        cfg,
    input  logic              line_inv,
    input  logic              pin,
    output logic              done,
    output logic [DATA_W-1:0] byte_o,
    output logic              ferr_o,
    output logic              perr_o
);
    localparam int SUB_W = $clog2(OVS);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [SUB_W-1:0] SUB_END  = SUB_W'(OVS - 1);
    localparam logic [SUB_W-1:0] SUB_HALF = SUB_W'(OVS / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    logic [1:0]        sync;
    logic              lin, lin_q;
    phase_e            phase;
    frame_cfg_t        cfg_q;
    logic [SUB_W-1:0]  sub;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  pos;
    logic              stop_left;
    logic [DATA_W-1:0] raw;
    logic              ferr, perr;

    // Bring the pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync <= 2'b00;
        end else begin
            sync <= {sync[0], pin};
        end
    end

    // Logical line level and the slot that the current data bit fills.
    always_comb begin
        lin = sync[1] ^ line_inv;
        pos = cfg_q.msb_first ? (IDX_LAST - idx) : idx;
    end

    // Frame state machine with mid-bit sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_q     <= 1'b0;
            phase     <= PH_IDLE;
            cfg_q     <= '0;
            sub       <= '0;
            idx       <= '0;
            stop_left <= 1'b0;
            raw       <= '0;
            ferr      <= 1'b0;
            perr      <= 1'b0;
            done      <= 1'b0;
            byte_o    <= '0;
            ferr_o    <= 1'b0;
            perr_o    <= 1'b0;
        end else begin
            done  <= 1'b0;
            lin_q <= lin;
            unique case (phase)
                PH_IDLE: begin
                    if (lin_q && !lin) begin
                        phase <= PH_START;
                        sub   <= '0;
                        cfg_q <= cfg;
                        ferr  <= 1'b0;
                        perr  <= 1'b0;
                    end
                end
                PH_START: begin
                    if (tick) begin
                        if (sub == SUB_HALF) begin
                            sub   <= '0;
                            idx   <= '0;
                            phase <= lin ? PH_IDLE : PH_DATA;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                end
                PH_DATA: begin
                    if (tick) begin
                        if (sub == SUB_END) begin
                            sub      <= '0;
                            raw[pos] <= lin;
                            if (idx == IDX_LAST) begin
                                stop_left <= cfg_q.two_stop;
                                phase     <= cfg_q.par_en ? PH_PAR : PH_STOP;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                end
                PH_PAR: begin
                    if (tick) begin
                        if (sub == SUB_END) begin
                            sub   <= '0;
                            perr  <= lin ^ (^raw) ^ cfg_q.par_odd;
                            phase <= PH_STOP;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                end
                PH_STOP: begin
                    if (tick) begin
                        if (sub == SUB_END) begin
                            sub <= '0;
                            if (!lin) begin
                                ferr <= 1'b1;
                            end
                            if (stop_left) begin
                                stop_left <= 1'b0;
                            end else begin
                                done   <= 1'b1;
                                byte_o <= cfg_q.data_inv ? ~raw : raw;
                                ferr_o <= ferr | !lin;
                                perr_o <= perr;
                                phase  <= PH_IDLE;
                            end
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/serline_uart.sv
// Module: serline_uart
// Top of the serial transceiver. It ties the shared tick divider to the
// transmitter and receiver, applies line polarity to the output pin, and holds
// each received byte with its flags until the consumer acknowledges it.
// Assumes: the settings change only while both directions are idle.
module serline_uart
    import serline_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OVS     = 16,
    parameter int CLK_DIV = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_data_inv,
    input  logic              cfg_line_inv,
    input  logic              cfg_msb_first,
    input  logic              cfg_two_stop,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              txd,
    input  logic              rxd,
    input  logic              rx_ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_frame_err,
    output logic              rx_par_err,
    output logic              rx_overrun
);
    frame_cfg_t        cfg;
    logic              tick;
    logic              tx_line;
    logic              rx_done;
    logic [DATA_W-1:0] rx_byte;
    logic              rx_ferr, rx_perr;

    // Gather the frame settings into one bundle.
    always_comb begin
        cfg.data_inv  = cfg_data_inv;
        cfg.msb_first = cfg_msb_first;
        cfg.two_stop  = cfg_two_stop;
        cfg.par_en    = cfg_par_en;
        cfg.par_odd   = cfg_par_odd;
    end

    serline_tick #(.DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    serline_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cfg   (cfg),
        .data  (tx_data),
        .valid (tx_valid),
        .ready (tx_ready),
        .line  (tx_line)
    );

    // Apply line polarity to the output pin.
    assign txd = tx_line ^ cfg_line_inv;

    serline_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cfg      (cfg),
        .line_inv (cfg_line_inv),
        .pin      (rxd),
        .done     (rx_done),
        .byte_o   (rx_byte),
        .ferr_o   (rx_ferr),
        .perr_o   (rx_perr)
    );

    // Hold the received byte and its flags until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data      <= '0;
            rx_valid     <= 1'b0;
            rx_frame_err <= 1'b0;
            rx_par_err   <= 1'b0;
            rx_overrun   <= 1'b0;
        end else if (rx_done) begin
            rx_data      <= rx_byte;
            rx_valid     <= 1'b1;
            rx_frame_err <= rx_ferr;
            rx_par_err   <= rx_perr;
            rx_overrun   <= rx_valid && !rx_ack;
        end else if (rx_ack) begin
            rx_valid     <= 1'b0;
            rx_frame_err <= 1'b0;
            rx_par_err   <= 1'b0;
            rx_overrun   <= 1'b0;
        end
    end
endmodule

// File: rtl/serline_chk.sv
// Module: serline_chk
// Property checker for serline_uart. It observes only the top-level ports.
// Assumes: the settings are stable while a frame is in flight.
module serline_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_line_inv,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              txd,
    input logic              rx_ack,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              rx_frame_err,
    input logic              rx_par_err,
    input logic              rx_overrun
);
    AST_TX_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (txd == !cfg_line_inv));  // R6

    AST_TX_START_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_ready) |-> (txd == cfg_line_inv));  // R1

    AST_TX_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);  // R1

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ack) |=> (rx_valid && $stable(rx_data)) || rx_overrun);  // R11

    AST_FLAGS_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame_err || rx_par_err || rx_overrun) |-> rx_valid);  // R11

    AST_OVERRUN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> $past(rx_valid));  // R10
endmodule

bind serline_uart serline_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_line_inv (cfg_line_inv),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .txd          (txd),
    .rx_ack       (rx_ack),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .rx_frame_err (rx_frame_err),
    .rx_par_err   (rx_par_err),
    .rx_overrun   (rx_overrun)
);

// File: tb/sim_serline_uart.sv
// Directed bench for serline_uart. Each task runs one scenario and checks its
// own results against frames built from the requirements.
module sim_serline_uart;
    localparam int DIV = 4;
    localparam int BIT = 16 * DIV;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       cfg_data_inv = 0, cfg_line_inv = 0, cfg_msb_first = 0;
    logic       cfg_two_stop = 0, cfg_par_en = 0, cfg_par_odd = 0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 0, rx_ack = 0;
    logic       tx_ready, txd, rxd;
    logic [7:0] rx_data;
    logic       rx_valid, rx_frame_err, rx_par_err, rx_overrun;
    logic       loop_en = 0, rxd_drv = 1'b1;

    assign rxd = loop_en ? txd : rxd_drv;

    serline_uart #(.CLK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_data_inv(cfg_data_inv), .cfg_line_inv(cfg_line_inv),
        .cfg_msb_first(cfg_msb_first), .cfg_two_stop(cfg_two_stop),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
        .rxd(rxd), .rx_ack(rx_ack), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err), .rx_overrun(rx_overrun)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected logical frame, bit 0 first on the line.
    task automatic build(input logic [7:0] d, output logic [15:0] fr, output int n);
        logic [7:0] p;
        p = cfg_data_inv ? ~d : d;
        fr = '1;
        fr[0] = 1'b0;
        for (int i = 0; i < 8; i++) fr[1+i] = cfg_msb_first ? p[7-i] : p[i];
        n = 9;
        if (cfg_par_en) begin
            fr[9] = (^p) ^ cfg_par_odd;
            n = 10;
        end
        n = n + (cfg_two_stop ? 2 : 1);
    endtask

    task automatic set_cfg(input logic di, li, msb, ts, pe, po);
        @(negedge clk);
        cfg_data_inv = di; cfg_line_inv = li; cfg_msb_first = msb;
        cfg_two_stop = ts; cfg_par_en = pe; cfg_par_odd = po;
        rxd_drv = ~li;
        repeat (2 * BIT) @(negedge clk);
    endtask

    task automatic ack();
        rx_ack = 1'b1;
        @(negedge clk);
        rx_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic drive(input logic [15:0] fr, input int n);
        for (int k = 0; k < n; k++) begin
            rxd_drv = fr[k] ^ cfg_line_inv;
            repeat (BIT) @(negedge clk);
        end
        rxd_drv = ~cfg_line_inv;
    endtask

    task automatic send_byte(input logic [7:0] d);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    // Transmit one byte and compare every bit of the frame at mid-bit.
    task automatic t_tx(input logic [7:0] d, input string req);
        logic [15:0] exp_fr, got;
        int n, t;
        build(d, exp_fr, n);
        got = '1;
        chk(txd == !cfg_line_inv, {req, " idle level"}, txd, !cfg_line_inv);
        send_byte(d);
        t = 0;
        while (txd == !cfg_line_inv && t < 4 * BIT) begin
            @(negedge clk);
            t++;
        end
        repeat (BIT / 2 - 1) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            got[k] = txd ^ cfg_line_inv;
            if (k < n - 1) repeat (BIT) @(negedge clk);
        end
        chk(got == exp_fr, {req, " tx frame"}, got, exp_fr);
        chk(!tx_ready, {req, " R3 busy in last stop"}, tx_ready, 0);
        repeat (BIT) @(negedge clk);
        chk(tx_ready, {req, " R1 idle after frame"}, tx_ready, 1);
    endtask

    // Drive one clean frame into rxd and check the delivered byte.
    task automatic t_rx(input logic [7:0] d, input string req);
        logic [15:0] fr;
        int n;
        build(d, fr, n);
        drive(fr, n);
        repeat (4) @(negedge clk);
        chk(rx_valid, {req, " rx valid"}, rx_valid, 1);
        chk(rx_data == d, {req, " rx data"}, rx_data, d);
        chk({rx_frame_err, rx_par_err, rx_overrun} == 3'b000, {req, " rx flags"},
            {rx_frame_err, rx_par_err, rx_overrun}, 0);
        ack();
    endtask

    task automatic t_loop(input logic [7:0] d, input string req);
        int t;
        loop_en = 1'b1;
        send_byte(d);
        t = 0;
        while (!rx_valid && t < 20 * BIT) begin
            @(negedge clk);
            t++;
        end
        chk(rx_valid && rx_data == d && !rx_par_err && !rx_frame_err,
            {req, " loopback"}, rx_data, d);
        ack();
        repeat (BIT) @(negedge clk);
        loop_en = 1'b0;
    endtask

    task automatic t_reset();
        chk(tx_ready, "R1 reset tx_ready", tx_ready, 1);
        chk(txd == 1'b1, "R1 reset txd mark", txd, 1);
        chk(!rx_valid, "R11 reset rx_valid", rx_valid, 0);
    endtask

    task automatic t_glitch();
        rxd_drv = cfg_line_inv;
        repeat (BIT / 4) @(negedge clk);
        rxd_drv = ~cfg_line_inv;
        repeat (2 * BIT) @(negedge clk);
        chk(!rx_valid, "R7 short start ignored", rx_valid, 0);
    endtask

    task automatic t_frame_err();
        logic [15:0] fr;
        int n;
        build(8'h3C, fr, n);
        fr[n-1] = 1'b0;
        drive(fr, n);
        repeat (4) @(negedge clk);
        chk(rx_valid && rx_frame_err, "R8 framing error", rx_frame_err, 1);
        chk(rx_data == 8'h3C, "R8 data with framing error", rx_data, 8'h3C);
        ack();
        chk(!rx_valid && !rx_frame_err, "R11 ack clears", {rx_valid, rx_frame_err}, 0);
    endtask

    task automatic t_par_err();
        logic [15:0] fr;
        int n;
        build(8'h71, fr, n);
        fr[9] = ~fr[9];
        drive(fr, n);
        repeat (4) @(negedge clk);
        chk(rx_valid && rx_par_err && !rx_frame_err, "R9 parity error",
            {rx_par_err, rx_frame_err}, 2);
        ack();
    endtask

    task automatic t_overrun();
        logic [15:0] fr;
        int n;
        build(8'h11, fr, n);
        drive(fr, n);
        repeat (BIT) @(negedge clk);
        chk(rx_valid && !rx_overrun, "R11 first byte held", rx_overrun, 0);
        build(8'hE2, fr, n);
        drive(fr, n);
        repeat (4) @(negedge clk);
        chk(rx_valid && rx_overrun, "R10 overrun flag", rx_overrun, 1);
        chk(rx_data == 8'hE2, "R10 newest byte kept", rx_data, 8'hE2);
        ack();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();

        set_cfg(0, 0, 0, 0, 0, 0);
        t_tx(8'h35, "R1");
        t_rx(8'hA6, "R1");
        set_cfg(0, 0, 1, 0, 0, 0);
        t_tx(8'h1D, "R2");
        t_rx(8'h1D, "R2");
        set_cfg(0, 0, 0, 1, 0, 0);
        t_tx(8'hC3, "R3");
        t_rx(8'hC3, "R3");
        set_cfg(0, 0, 0, 0, 1, 0);
        t_tx(8'h07, "R4 even");
        t_rx(8'h07, "R4 even");
        set_cfg(0, 0, 0, 0, 1, 1);
        t_tx(8'h07, "R4 odd");
        t_rx(8'h5B, "R4 odd");
        set_cfg(1, 0, 0, 0, 1, 0);
        t_tx(8'h5A, "R5");
        t_rx(8'h5A, "R5");
        set_cfg(0, 1, 0, 0, 0, 0);
        chk(txd == 1'b0, "R6 idle low", txd, 0);
        t_tx(8'h96, "R6");
        t_rx(8'h96, "R6");

        for (int c = 0; c < 4; c++) begin
            set_cfg(c[0], c[1], 1, 1, 1, 1);
            t_loop(8'h4D ^ 8'(c), "R5 R6 combination");
        end

        set_cfg(0, 1, 0, 0, 0, 0);
        t_glitch();
        t_rx(8'h2F, "R7 after glitch");
        set_cfg(0, 0, 0, 0, 0, 0);
        t_frame_err();
        set_cfg(0, 0, 0, 0, 1, 0);
        t_par_err();
        set_cfg(0, 0, 0, 0, 0, 0);
        t_overrun();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule